// File: doc/BRIEF.md
# I2C Status-First Read Sequencer

This block is the read-side byte sequencer of an I2C slave port. Bit-level framing is handled elsewhere. Start and stop detection, the address match with the read bit, the per-bit shift strobe, the end of each ninth clock and the sampled acknowledge all arrive as single-cycle input pulses. Every read transaction begins with the status byte. Zero, one or two staged data bytes may follow, depending on the data-available flag and the two-byte flag. When the master keeps clocking past the staged data, the block returns 0xFF.

The block sends each byte MSB first on its serial output. A staged byte counts as consumed when its ninth clock completes, whether the master acknowledged it or not. Each such byte is reported to the staging register by a one-cycle consume pulse, with a select bit that says which byte was taken. The status byte and filler bytes are never reported as consumed. A NACK, a repeated start or a stop sends the sequencer back to idle, and the next read starts again at the status byte.

Top module: `rdseq_top`

## Requirements
- R1: While reset is high and in the cycle after it, `busy_o` is 0, `consume_o` is 0, `sda_o` is 1 and `cur_byte_o` is 0xFF.
- R2: One cycle after an `addr_rd_i` pulse, `busy_o` is 1 and `cur_byte_o` equals `status_i` as sampled at that pulse, so the first byte of every read is the status byte.
- R3: Bits leave on `sda_o` MSB first. Each `bit_tick_i` pulse moves the next lower bit onto `sda_o` on the following cycle.
- R4: With `dav_i`=0 at the start of the read, no byte of the transaction ever produces a consume pulse, and every byte after the status byte is 0xFF.
- R5: With `dav_i`=1 and `two_i`=0, the byte after an acknowledged status byte is `data0_i`. Its ninth clock gives one consume pulse with `consume_sel_o`=0, whether it was ACKed or NACKed.
- R6: With `dav_i`=1 and `two_i`=1, `data0_i` follows the status byte, then `data1_i`. Their ninth clocks give consume pulses with `consume_sel_o`=0 and then 1.
- R7: Bytes clocked beyond the staged count are 0xFF and produce no consume pulse.
- R8: A `byte_done_i` with `ack_i`=0 (NACK) makes `busy_o` 0 and `sda_o` 1 one cycle later.
- R9: A `start_i` or `stop_i` pulse in mid-transaction makes `busy_o` 0 and `sda_o` 1 one cycle later, with no consume pulse. The next `addr_rd_i` begins again with the status byte.
- R10: While `busy_o` is 0, `bit_tick_i` and `byte_done_i` are ignored: `sda_o` stays 1 and no consume pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start or repeated start seen on the bus |
| stop_i | input | 1 | Stop seen on the bus |
| addr_rd_i | input | 1 | Own address matched with the read bit; a read begins |
| bit_tick_i | input | 1 | Advance the serial output to the next bit |
| byte_done_i | input | 1 | Ninth clock of the current byte has completed |
| ack_i | input | 1 | Acknowledge sampled on that ninth clock (1 = ACK) |
| status_i | input | 8 | Status byte to return first |
| dav_i | input | 1 | Staged data available |
| two_i | input | 1 | Two staged bytes (else one) |
| data0_i | input | 8 | First staged byte |
| data1_i | input | 8 | Second staged byte |
| sda_o | output | 1 | Serial data bit to drive (1 = released) |
| cur_byte_o | output | 8 | Byte currently being sent |
| busy_o | output | 1 | Read transaction in progress |
| consume_o | output | 1 | One-cycle pulse: a staged byte was consumed |
| consume_sel_o | output | 1 | Which staged byte was consumed (0 first, 1 second) |

## Verification
The table-driven reads combine the flag settings (no data, one byte, two bytes) with read lengths from one to four bytes. This shows whether the status byte always comes first, and whether the sequencer tells a staged byte from filler at each position. Reads that end on the staged byte and reads that run past it tell apart the rule that a NACKed last byte still counts from the rule that filler never counts. Directed cases abort a read part-way through a byte with a start and with a stop, and strobe the bit and byte inputs while idle. These show that aborts return to the status position and that idle strobes have no effect.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  // Position of the byte being sent within a read transaction.
  // The numeric order matters: data slots are compared against the staged count.
  typedef enum logic [1:0] {
    SLOT_STATUS = 2'd0,
    SLOT_DATA0  = 2'd1,
    SLOT_DATA1  = 2'd2,
    SLOT_FILL   = 2'd3
  } slot_e;
endpackage

// File: rtl/rdseq_slot_ctrl.sv
module rdseq_slot_ctrl
  import rdseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       addr_rd_i,
  input  logic       byte_done_i,
  input  logic       ack_i,
  input  logic       dav_i,
  input  logic       two_i,
  output logic       busy_o,
  output logic       load_o,
  output logic       clear_o,
  output slot_e      next_slot_o,
  output logic [1:0] next_avail_o,
  output logic       consume_o,
  output logic       consume_sel_o
);
  slot_e      slot_q;
  logic [1:0] avail_q;
  logic       abort_c;
  logic       advance_c;
  logic       end_c;
  logic       staged_c;

  assign abort_c   = start_i | stop_i;
  assign advance_c = busy_o & byte_done_i & ~addr_rd_i & ~abort_c;
  assign end_c     = advance_c & ~ack_i;
  assign staged_c  = (slot_q != SLOT_STATUS) && (2'(slot_q) <= avail_q);

  always_comb begin
    next_avail_o = avail_q;
    next_slot_o  = slot_q;
    if (addr_rd_i) begin
      next_avail_o = dav_i ? (two_i ? 2'd2 : 2'd1) : 2'd0;
      next_slot_o  = SLOT_STATUS;
    end else if (slot_q != SLOT_FILL) begin
      next_slot_o  = slot_e'(2'(slot_q) + 2'd1);
    end
  end

  assign load_o  = ~abort_c & (addr_rd_i | (advance_c & ack_i));
  assign clear_o = abort_c | end_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o        <= 1'b0;
      slot_q        <= SLOT_STATUS;
      avail_q       <= 2'd0;
      consume_o     <= 1'b0;
      consume_sel_o <= 1'b0;
    end else begin
      consume_o <= 1'b0;
      if (abort_c) begin
        busy_o <= 1'b0;
        slot_q <= SLOT_STATUS;
      end else if (addr_rd_i) begin
        busy_o  <= 1'b1;
        slot_q  <= SLOT_STATUS;
        avail_q <= next_avail_o;
      end else if (advance_c) begin
        if (staged_c) begin
          consume_o     <= 1'b1;
          consume_sel_o <= (slot_q == SLOT_DATA1);
        end
        if (ack_i) begin
          slot_q <= next_slot_o;
        end else begin
          busy_o <= 1'b0;
          slot_q <= SLOT_STATUS;
        end
      end
    end
  end

  // R9
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i || stop_i) |=> (!busy_o && !consume_o));

  // R8
  nack_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && byte_done_i && !ack_i && !addr_rd_i) |=> !busy_o);

  // R10
  consume_cause_chk: assert property (@(posedge clk) disable iff (rst)
    consume_o |-> $past(busy_o && byte_done_i));

  // R4
  no_data_no_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && avail_q == 2'd0) |=> !consume_o);
endmodule

// File: rtl/rdseq_byte_sel.sv
module rdseq_byte_sel
  import rdseq_pkg::*;
#(
  parameter int          BYTE_W = 8,
  parameter logic [BYTE_W-1:0] FILL = '1
) (
  input  slot_e             slot_i,
  input  logic [1:0]        avail_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [BYTE_W-1:0] data0_i,
  input  logic [BYTE_W-1:0] data1_i,
  output logic [BYTE_W-1:0] byte_o
);
  always_comb begin
    byte_o = FILL;
    if (slot_i == SLOT_STATUS) begin
      byte_o = status_i;
    end else if (2'(slot_i) <= avail_i) begin
      byte_o = (slot_i == SLOT_DATA0) ? data0_i : data1_i;
    end
  end
endmodule

// File: rtl/rdseq_shifter.sv
module rdseq_shifter #(
  parameter int          BYTE_W = 8,
  parameter logic [BYTE_W-1:0] FILL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              busy_i,
  input  logic              bit_tick_i,
  output logic              sda_o,
  output logic [BYTE_W-1:0] cur_byte_o
);
  logic [BYTE_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      shreg_q    <= FILL;
      cur_byte_o <= FILL;
    end else if (load_i) begin
      shreg_q    <= byte_i;
      cur_byte_o <= byte_i;
    end else if (busy_i && bit_tick_i) begin
      shreg_q <= {shreg_q[BYTE_W-2:0], 1'b1};
    end
  end

  assign sda_o = shreg_q[BYTE_W-1];

  // R10
  idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_i && !load_i && !clear_i) |=> $stable(sda_o));

  // R3
  msb_next_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_i && bit_tick_i && !load_i && !clear_i) |=> (sda_o == $past(shreg_q[BYTE_W-2])));
endmodule

// File: rtl/rdseq_top.sv
module rdseq_top
  import rdseq_pkg::*;
#(
  parameter int          BYTE_W = 8,
  parameter logic [BYTE_W-1:0] FILL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_rd_i,
  input  logic              bit_tick_i,
  input  logic              byte_done_i,
  input  logic              ack_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic              dav_i,
  input  logic              two_i,
  input  logic [BYTE_W-1:0] data0_i,
  input  logic [BYTE_W-1:0] data1_i,
  output logic              sda_o,
  output logic [BYTE_W-1:0] cur_byte_o,
  output logic              busy_o,
  output logic              consume_o,
  output logic              consume_sel_o
);
  logic              load_w;
  logic              clear_w;
  slot_e             next_slot_w;
  logic [1:0]        next_avail_w;
  logic [BYTE_W-1:0] next_byte_w;

  rdseq_slot_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .addr_rd_i    (addr_rd_i),
    .byte_done_i  (byte_done_i),
    .ack_i        (ack_i),
    .dav_i        (dav_i),
    .two_i        (two_i),
    .busy_o       (busy_o),
    .load_o       (load_w),
    .clear_o      (clear_w),
    .next_slot_o  (next_slot_w),
    .next_avail_o (next_avail_w),
    .consume_o    (consume_o),
    .consume_sel_o(consume_sel_o)
  );

  rdseq_byte_sel #(.BYTE_W(BYTE_W), .FILL(FILL)) u_sel (
    .slot_i  (next_slot_w),
    .avail_i (next_avail_w),
    .status_i(status_i),
    .data0_i (data0_i),
    .data1_i (data1_i),
    .byte_o  (next_byte_w)
  );

  rdseq_shifter #(.BYTE_W(BYTE_W), .FILL(FILL)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (clear_w),
    .load_i    (load_w),
    .byte_i    (next_byte_w),
    .busy_i    (busy_o),
    .bit_tick_i(bit_tick_i),
    .sda_o     (sda_o),
    .cur_byte_o(cur_byte_o)
  );

  // R2
  status_first_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_rd_i && !start_i && !stop_i) |=> (busy_o && cur_byte_o == $past(status_i)));
endmodule

// File: tb/rdseq_top_bench.sv
module rdseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {dav, two, bytes_read[2:0], status[7:0], data0[7:0], data1[7:0]}
  localparam logic [28:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 3'd1, 8'hA5, 8'h11, 8'h22},
    {1'b0, 1'b0, 3'd2, 8'h3C, 8'h11, 8'h22},
    {1'b1, 1'b0, 3'd2, 8'hC3, 8'h5A, 8'h22},
    {1'b1, 1'b0, 3'd3, 8'h81, 8'h96, 8'h22},
    {1'b1, 1'b1, 3'd3, 8'hF0, 8'h0F, 8'h69},
    {1'b1, 1'b1, 3'd4, 8'h7E, 8'hB4, 8'h2D},
    {1'b1, 1'b1, 3'd1, 8'h42, 8'hB4, 8'h2D}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, stop_i = 0, addr_rd_i = 0, bit_tick_i = 0, byte_done_i = 0, ack_i = 0;
  logic [7:0] status_i = 0, data0_i = 0, data1_i = 0;
  logic dav_i = 0, two_i = 0;
  logic sda_o, busy_o, consume_o, consume_sel_o;
  logic [7:0] cur_byte_o;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdseq_top u_rdseq_top (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .addr_rd_i(addr_rd_i),
    .bit_tick_i(bit_tick_i), .byte_done_i(byte_done_i), .ack_i(ack_i),
    .status_i(status_i), .dav_i(dav_i), .two_i(two_i), .data0_i(data0_i), .data1_i(data1_i),
    .sda_o(sda_o), .cur_byte_o(cur_byte_o), .busy_o(busy_o),
    .consume_o(consume_o), .consume_sel_o(consume_sel_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic begin_read();
    addr_rd_i = 1;
    @(negedge clk);
    addr_rd_i = 0;
  endtask

  // Shift one byte out, checking each bit, then end it with the given acknowledge.
  task automatic xfer_byte(input logic [7:0] exp, input logic ack,
                           input bit exp_cons, input bit exp_sel, input string req);
    check(cur_byte_o == exp, req, cur_byte_o, exp);
    for (int i = 7; i >= 0; i--) begin
      check(sda_o == exp[i], "R3", sda_o, exp[i]);
      bit_tick_i = 1;
      @(negedge clk);
      bit_tick_i = 0;
    end
    byte_done_i = 1;
    ack_i = ack;
    @(negedge clk);
    byte_done_i = 0;
    ack_i = 0;
    check(consume_o == exp_cons, req, consume_o, exp_cons);
    if (exp_cons) check(consume_sel_o == exp_sel, req, consume_sel_o, exp_sel);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(busy_o == 0 && consume_o == 0, "R1", busy_o, 0);
    check(sda_o == 1 && cur_byte_o == 8'hFF, "R1", cur_byte_o, 8'hFF);
    rst = 0;
    @(negedge clk);
    check(busy_o == 0 && sda_o == 1, "R1", busy_o, 0);

    // Table-driven reads
    for (int v = 0; v < NVEC; v++) begin
      logic [28:0] e;
      int avail;
      int n;
      e = VECS[v];
      dav_i = e[28]; two_i = e[27]; n = int'(e[26:24]);
      status_i = e[23:16]; data0_i = e[15:8]; data1_i = e[7:0];
      avail = dav_i ? (two_i ? 2 : 1) : 0;
      begin_read();
      check(busy_o == 1, "R2", busy_o, 1);
      for (int k = 0; k < n; k++) begin
        logic [7:0] exp;
        bit cons;
        string req;
        if (k == 0) begin exp = status_i; req = "R2"; end
        else if (k <= avail) begin
          exp = (k == 1) ? data0_i : data1_i;
          req = (avail == 2) ? "R6" : "R5";
        end else begin
          exp = 8'hFF;
          req = (avail == 0) ? "R4" : "R7";
        end
        cons = (k >= 1) && (k <= avail);
        xfer_byte(exp, (k != n - 1), cons, (k == 2), req);
      end
      // R8 last byte was NACKed
      check(busy_o == 0 && sda_o == 1, "R8", busy_o, 0);
      @(negedge clk);
    end

    // R9 repeated start mid data byte
    dav_i = 1; two_i = 1; status_i = 8'h5C; data0_i = 8'hE7; data1_i = 8'h18;
    begin_read();
    xfer_byte(8'h5C, 1, 0, 0, "R2");
    for (int i = 0; i < 3; i++) begin
      bit_tick_i = 1; @(negedge clk); bit_tick_i = 0;
    end
    start_i = 1; @(negedge clk); start_i = 0;
    check(busy_o == 0 && sda_o == 1, "R9", busy_o, 0);
    check(consume_o == 0, "R9", consume_o, 0);
    begin_read();
    xfer_byte(8'h5C, 1, 0, 0, "R9");
    xfer_byte(8'hE7, 1, 1, 0, "R6");
    // R9 stop mid second data byte
    bit_tick_i = 1; @(negedge clk); bit_tick_i = 0;
    stop_i = 1; @(negedge clk); stop_i = 0;
    check(busy_o == 0 && sda_o == 1, "R9", busy_o, 0);
    check(consume_o == 0, "R9", consume_o, 0);

    // R10 strobes while idle
    bit_tick_i = 1; @(negedge clk); bit_tick_i = 0;
    check(sda_o == 1, "R10", sda_o, 1);
    byte_done_i = 1; ack_i = 1; @(negedge clk); byte_done_i = 0; ack_i = 0;
    check(consume_o == 0 && busy_o == 0, "R10", consume_o, 0);

    // R5 single staged byte NACKed still consumed, new read starts at status
    dav_i = 1; two_i = 0; status_i = 8'h99; data0_i = 8'h24;
    begin_read();
    xfer_byte(8'h99, 1, 0, 0, "R2");
    xfer_byte(8'h24, 0, 1, 0, "R5");
    check(busy_o == 0, "R8", busy_o, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule